// File: doc/BRIEF.md
# Save-Area Region Lock Register

This block holds a one-byte configuration register that lets boot firmware discover, and then seal, a fixed stretch of low memory that serves as the system-management save area. Before the feature is used, the register is fully writable but holds nothing: any value other than the query code is thrown away. Writing the query code makes the register report that the area is backed by RAM and leaves only the lock bit writable. Writing the lock bit seals the register, and after that it ignores every write until reset.

A memory-side decoder classifies each access against the protected window. While the register is sealed, a non-privileged read of the window returns all ones and a non-privileged write is dropped. An access made in system-management mode is routed to DRAM instead. While the register is not sealed, every access takes the normal route. A configuration input gates the whole feature. When that input is low, register writes have no effect and the decoder stays on the normal route.

Top module: `smbase_guard`

## Requirements
- R1: After synchronous reset the register reads 0x00, its write mask is 0xFF, dec_valid is 0, and accesses take the normal route (dec_route = 0).
- R2: With the write mask at 0xFF, writing the query code 0xFF makes the register read the in-RAM code 0x01 on the next cycle. The write mask then becomes the lock bit alone, which is bit 1 (0x02).
- R3: With the write mask at 0xFF, a write of any value other than 0xFF is discarded, and the register keeps reading 0x00.
- R4: With the write mask at 0x02, a write with bit 1 set makes the register read exactly 0x02 (locked). A write with bit 1 clear leaves it reading 0x01, and all other data bits are ignored.
- R5: Once locked, the register keeps reading 0x02 and ignores every write until reset.
- R6: While feature_en is 0, register writes have no effect and the decoder reports the normal route.
- R7: A write whose byte address differs from REG_ADDR has no effect on the register.
- R8: While locked and enabled, a non-SMM access inside [REGION_BASE, REGION_BASE+REGION_SIZE) gets the sink route (dec_route = 1). A read from the sink returns all ones on dec_rdata, and a write to it is reported dropped (dec_wr_drop = 1).
- R9: While locked and enabled, an SMM access inside the window gets the DRAM route (dec_route = 2), and no SMM access is ever routed to the sink.
- R10: When the register is not locked, or the address lies outside the window, an access gets the normal route. Every decode result appears one cycle after acc_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feature_en | input | 1 | Enables the whole save-area lock feature |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | CFG_AW | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Current register value |
| acc_valid | input | 1 | Memory access request |
| acc_addr | input | MEM_AW | Memory access address |
| acc_smm | input | 1 | Access made in system-management mode |
| acc_write | input | 1 | Access is a write |
| dec_valid | output | 1 | Decode result valid, one cycle after acc_valid |
| dec_route | output | 2 | 0 normal, 1 all-ones sink, 2 DRAM window |
| dec_rdata | output | DATA_W | All ones for a sink read, zero otherwise |
| dec_wr_drop | output | 1 | Write hit the sink and was dropped |

## Verification
The bench builds the block with MEM_AW = 20, so a random address falls inside the 128 KiB window at 0x30000 about one time in eight. The window edges 0x2FFFF, 0x30000, 0x4FFFF and 0x50000 are also reached directly. CFG_AW stays at 8, and random write data is biased toward the query code and the lock bit. Together with occasional resets and toggling of feature_en, this walks the register through the open, negotiated and locked states many times.

// File: rtl/smbase_lock_pkg.sv
package smbase_lock_pkg;
  typedef enum logic [1:0] {
    ROUTE_NORMAL = 2'd0,
    ROUTE_SINK   = 2'd1,
    ROUTE_DRAM   = 2'd2
  } route_e;

  localparam logic [7:0] QUERY_CODE  = 8'hFF;
  localparam logic [7:0] IN_RAM_CODE = 8'h01;
  localparam logic [7:0] LOCK_BIT    = 8'h02;
  localparam logic [7:0] OPEN_MASK   = 8'hFF;
endpackage

// File: rtl/smbase_lock_fsm.sv
module smbase_lock_fsm
  import smbase_lock_pkg::*;
#(
  parameter int unsigned CFG_AW = 8,
  parameter logic [CFG_AW-1:0] REG_ADDR = 8'h9C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feature_en,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        rdata,
  output logic              locked
);
  logic [7:0] val_q, mask_q;
  logic [7:0] merged;
  logic       wr_hit;

  assign wr_hit = cfg_wr && feature_en && (cfg_addr == REG_ADDR);
  assign merged = (val_q & ~mask_q) | (cfg_wdata & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= 8'h00;
      mask_q <= OPEN_MASK;
    end else if (wr_hit) begin
      if (merged == QUERY_CODE) begin
        val_q  <= IN_RAM_CODE;
        mask_q <= LOCK_BIT;
      end else if (mask_q == OPEN_MASK) begin
        val_q  <= 8'h00;
      end else if ((merged & LOCK_BIT) != 8'h00) begin
        val_q  <= LOCK_BIT;
        mask_q <= mask_q & ~LOCK_BIT;
      end else begin
        val_q  <= merged;
      end
    end
  end

  assign rdata  = val_q;
  assign locked = ((val_q & LOCK_BIT) != 8'h00) && ((mask_q & LOCK_BIT) == 8'h00);

  // R2
  query_chk: assert property (@(posedge clk) disable iff (rst)
    (feature_en && cfg_wr && cfg_addr == REG_ADDR && cfg_wdata == QUERY_CODE && rdata == 8'h00)
    |=> rdata == IN_RAM_CODE);
  // R3
  discard_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wdata != QUERY_CODE && rdata == 8'h00) |=> rdata == 8'h00);
  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked && rdata == LOCK_BIT);
  // R6
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!feature_en && rdata == IN_RAM_CODE) |=> rdata == IN_RAM_CODE);
  // R7
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr != REG_ADDR && rdata == IN_RAM_CODE) |=> rdata == IN_RAM_CODE);
endmodule

// File: rtl/smbase_window_dec.sv
module smbase_window_dec
  import smbase_lock_pkg::*;
#(
  parameter int unsigned MEM_AW = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [MEM_AW-1:0] REGION_BASE = 'h30000,
  parameter logic [MEM_AW-1:0] REGION_SIZE = 'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_active,
  input  logic              acc_valid,
  input  logic [MEM_AW-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_write,
  output logic              dec_valid,
  output logic [1:0]        dec_route,
  output logic [DATA_W-1:0] dec_rdata,
  output logic              dec_wr_drop
);
  localparam logic [MEM_AW:0] WIN_LO = {1'b0, REGION_BASE};
  localparam logic [MEM_AW:0] WIN_HI = {1'b0, REGION_BASE} + {1'b0, REGION_SIZE};

  logic   in_win;
  route_e route_d;

  assign in_win = ({1'b0, acc_addr} >= WIN_LO) && ({1'b0, acc_addr} < WIN_HI);

  always_comb begin
    route_d = ROUTE_NORMAL;
    if (lock_active && in_win)
      route_d = acc_smm ? ROUTE_DRAM : ROUTE_SINK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      dec_route   <= ROUTE_NORMAL;
      dec_rdata   <= '0;
      dec_wr_drop <= 1'b0;
    end else begin
      dec_valid   <= acc_valid;
      dec_route   <= acc_valid ? route_d : ROUTE_NORMAL;
      dec_rdata   <= (acc_valid && route_d == ROUTE_SINK && !acc_write) ? '1 : '0;
      dec_wr_drop <= acc_valid && route_d == ROUTE_SINK && acc_write;
    end
  end

  // R10
  normal_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !lock_active) |=> dec_valid && dec_route == ROUTE_NORMAL);
  // R9
  smm_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_smm) |=> dec_route != ROUTE_SINK && !dec_wr_drop);
  // R8
  sink_data_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_route == ROUTE_SINK && !dec_wr_drop) |-> dec_rdata == '1);
endmodule

// File: rtl/smbase_guard.sv
module smbase_guard #(
  parameter int unsigned CFG_AW = 8,
  parameter int unsigned MEM_AW = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [CFG_AW-1:0] REG_ADDR = 8'h9C,
  parameter logic [MEM_AW-1:0] REGION_BASE = 'h30000,
  parameter logic [MEM_AW-1:0] REGION_SIZE = 'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feature_en,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              acc_valid,
  input  logic [MEM_AW-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_write,
  output logic              dec_valid,
  output logic [1:0]        dec_route,
  output logic [DATA_W-1:0] dec_rdata,
  output logic              dec_wr_drop
);
  logic locked;

  smbase_lock_fsm #(.CFG_AW(CFG_AW), .REG_ADDR(REG_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .feature_en(feature_en),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rdata(reg_rdata), .locked(locked)
  );

  smbase_window_dec #(
    .MEM_AW(MEM_AW), .DATA_W(DATA_W),
    .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE)
  ) u_dec (
    .clk(clk), .rst(rst), .lock_active(locked && feature_en),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm),
    .acc_write(acc_write), .dec_valid(dec_valid), .dec_route(dec_route),
    .dec_rdata(dec_rdata), .dec_wr_drop(dec_wr_drop)
  );
endmodule

// File: tb/test_smbase_guard.sv
module test_smbase_guard;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned MEM_AW = 20;
  localparam int unsigned DATA_W = 32;
  localparam logic [CFG_AW-1:0] REG_A = 8'h9C;

  logic clk = 1'b0, rst = 1'b1, feature_en = 1'b0, cfg_wr = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, reg_rdata;
  logic acc_valid = 1'b0, acc_smm = 1'b0, acc_write = 1'b0;
  logic [MEM_AW-1:0] acc_addr = '0;
  logic dec_valid, dec_wr_drop;
  logic [1:0] dec_route;
  logic [DATA_W-1:0] dec_rdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] m_val = 8'h00, m_mask = 8'hFF;

  always #5 clk = ~clk;

  smbase_guard #(.CFG_AW(CFG_AW), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .REG_ADDR(REG_A),
    .REGION_BASE(20'h30000), .REGION_SIZE(20'h20000)) i_smbase_guard (
    .clk(clk), .rst(rst), .feature_en(feature_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm),
    .acc_write(acc_write), .dec_valid(dec_valid), .dec_route(dec_route),
    .dec_rdata(dec_rdata), .dec_wr_drop(dec_wr_drop));

  function automatic logic [15:0] model_next(input logic [7:0] v, m, d);
    logic [7:0] mg;
    mg = (v & ~m) | (d & m);
    if (mg == 8'hFF)         return {8'h01, 8'h02};
    else if (m == 8'hFF)     return {8'h00, 8'hFF};
    else if (mg[1])          return {8'h02, m & 8'hFD};
    else                     return {mg, m};
  endfunction

  function automatic logic m_locked();
    return m_val[1] && !m_mask[1] && feature_en;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_val = 8'h00; m_mask = 8'hFF;
  endtask

  task automatic wr(input string req, input logic [CFG_AW-1:0] a, input logic [7:0] d);
    logic [15:0] nx;
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
    if (feature_en && a == REG_A) begin
      nx = model_next(m_val, m_mask, d);
      m_val = nx[15:8]; m_mask = nx[7:0];
    end
    chk(req, reg_rdata, m_val);
  endtask

  task automatic acc(input string req, input logic [MEM_AW-1:0] a, input logic smm, input logic w);
    logic in_w;
    logic [1:0] er;
    in_w = (a >= 20'h30000) && (a <= 20'h4FFFF);
    er = (m_locked() && in_w) ? (smm ? 2'd2 : 2'd1) : 2'd0;
    @(negedge clk); acc_valid = 1'b1; acc_addr = a; acc_smm = smm; acc_write = w;
    @(negedge clk); acc_valid = 1'b0;
    chk(req, {dec_valid, dec_route}, {1'b1, er});
    chk(req, dec_rdata, (er == 2'd1 && !w) ? {DATA_W{1'b1}} : '0);
    chk(req, dec_wr_drop, (er == 2'd1 && w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset value", reg_rdata, 8'h00);
    chk("R1 reset dec_valid", dec_valid, 1'b0);
    feature_en = 1'b1;
    acc("R1 reset route", 20'h30000, 1'b0, 1'b0);
    wr("R3 open discard 0x55", REG_A, 8'h55);
    wr("R3 open discard lock bit", REG_A, 8'h02);
    wr("R7 other address", REG_A + 8'h1, 8'hFF);
    feature_en = 1'b0;
    wr("R6 disabled query", REG_A, 8'hFF);
    feature_en = 1'b1;
    wr("R2 query", REG_A, 8'hFF);
    acc("R10 unlocked in window", 20'h30000, 1'b0, 1'b0);
    wr("R4 lock bit clear", REG_A, 8'hFD);
    wr("R4 lock", REG_A, 8'h02);
    wr("R5 locked ignores query", REG_A, 8'hFF);
    wr("R5 locked ignores zero", REG_A, 8'h00);
    acc("R8 sink read low edge", 20'h30000, 1'b0, 1'b0);
    acc("R8 sink write dropped", 20'h40000, 1'b0, 1'b1);
    acc("R8 sink read high edge", 20'h4FFFF, 1'b0, 1'b0);
    acc("R10 above window", 20'h50000, 1'b0, 1'b0);
    acc("R10 below window", 20'h2FFFF, 1'b0, 1'b0);
    acc("R9 smm read", 20'h30000, 1'b1, 1'b0);
    acc("R9 smm write", 20'h4FFFF, 1'b1, 1'b1);
    feature_en = 1'b0;
    acc("R6 disabled route", 20'h30000, 1'b0, 1'b0);
    feature_en = 1'b1;
    do_reset();
    chk("R1 value after second reset", reg_rdata, 8'h00);
    acc("R1 route after reset", 20'h38000, 1'b0, 1'b1);

    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      if (r < 2) do_reset();
      feature_en = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 1) == 0) begin
        case ($urandom_range(0, 3))
          0: d = 8'hFF;
          1: d = 8'h02;
          default: d = 8'($urandom);
        endcase
        wr("R4 random write", ($urandom_range(0, 3) == 0) ? 8'($urandom) : REG_A, d);
      end else begin
        acc("R8 random access", 20'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule